// File: doc/BRIEF.md
# DMA Interrupt Status and Control Register

This block is the 32-bit interrupt register of a seven-channel DMA engine. The CPU writes it to set per-channel interrupt enables, a master enable and 15 bits of general storage. The CPU also writes ones to clear channel flags. The DMA channels feed it one-cycle pulses: one when a transfer completes and one when a transfer hits a bus error. The block drives one level interrupt line to the system interrupt controller.

A completion pulse records a channel flag only when both that channel's enable and the master enable are on. A bus-error pulse always records the channel flag and a sticky bus-error bit. The master flag is derived from the stored state. It appears as the top bit of the readback word and as the interrupt output.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset the read word `rdData` is 0x00000000 and `irqOut` is low.
- R2: A write with `wrEn` high stores `wrData[23:0]` into the register on the next clock edge. Bits 0 to 14 are storage, bit 15 is the bus-error bit, bits 16 to 22 are the enables for channels 0 to 6, and bit 23 is the master enable. A bus-error pulse in the same cycle overrides bit 15 to one.
- R3: Bit 31 ignores written data. It always reads as the master flag, so it equals `irqOut`.
- R4: A `doneStb[c]` pulse sets the flag at bit 24+c on the next edge when enable bit 16+c and master enable bit 23 are both one.
- R5: A `doneStb[c]` pulse leaves flag 24+c unchanged when either enable bit 16+c or bit 23 is zero. The decision uses the enables held before that edge.
- R6: A `busErrStb[c]` pulse sets bit 15 and flag 24+c on the next edge, whatever the enable bits hold.
- R7: Writing a one to bit 24+c clears that flag. Writing a zero leaves the flag as it was. Flags hold their value when no write, completion or bus error touches them.
- R8: When a set (completion or bus error) and a one-written clear hit the same flag in one cycle, the flag ends up set.
- R9: The master flag and `irqOut` are high when bit 15 is set, or when bit 23 is set and any flag in bits 24 to 30 is set. Otherwise both are low.
- R10: Bits 0 to 14 change only on a write and have no effect on `irqOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| doneStb | input | 7 | Per-channel transfer-complete pulses |
| busErrStb | input | 7 | Per-channel bus-error pulses |
| rdData | output | 32 | Current register contents, including the master flag at bit 31 |
| irqOut | output | 1 | Level interrupt to the system interrupt controller |

## Verification
Every write, completion and bus-error effect lands on the clock edge that samples it. The register contents and `irqOut` show the result in the same cycle after that edge, with no further delay. The interrupt depends only on registered state, so it is never due earlier than the register contents. The driver applies each stimulus at a falling edge and, once the following rising edge has passed, queues the expected word and interrupt level. The monitor compares them at the next falling edge, which is the first settled point after the update.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int CH_COUNT  = 7;
  localparam int DATA_W    = 32;
  localparam int LOW_W     = 15;
  localparam int BERR_BIT  = LOW_W;
  localparam int EN_LO     = BERR_BIT + 1;
  localparam int MEN_BIT   = EN_LO + CH_COUNT;
  localparam int FLAG_LO   = MEN_BIT + 1;
  localparam int MFLAG_BIT = FLAG_LO + CH_COUNT;

  typedef struct packed {
    logic                ctrlWe;
    logic                busErrSet;
    logic [CH_COUNT-1:0] flagSet;
    logic [CH_COUNT-1:0] flagClr;
  } strobe_t;
endpackage

// File: rtl/dma_irq_strobe_gen.sv
module dma_irq_strobe_gen
  import dma_irq_pkg::*;
(
  input  logic                wrEn,
  input  logic [CH_COUNT-1:0] wrClr,
  input  logic [CH_COUNT-1:0] doneStb,
  input  logic [CH_COUNT-1:0] busErrStb,
  input  logic [CH_COUNT-1:0] chEn,
  input  logic                masterEn,
  output strobe_t             stb
);
  always_comb begin
    stb.ctrlWe    = wrEn;
    stb.busErrSet = |busErrStb;
    for (int i = 0; i < CH_COUNT; i++) begin
      stb.flagSet[i] = busErrStb[i] | (doneStb[i] & chEn[i] & masterEn);
      // a set in the same cycle outranks a one-written clear
      stb.flagClr[i] = wrEn & wrClr[i] & ~stb.flagSet[i];
    end
  end
endmodule

// File: rtl/dma_irq_regfile.sv
module dma_irq_regfile
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [MEN_BIT:0]  wrCtrl,
  output logic [CH_COUNT-1:0] chEn,
  output logic              masterEn,
  output logic [DATA_W-1:0] regWord,
  output logic              irqOut
);
  logic [LOW_W-1:0]    lowBits;
  logic                busErr;
  logic [CH_COUNT-1:0] flags;
  logic                masterFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowBits  <= '0;
      busErr   <= 1'b0;
      chEn     <= '0;
      masterEn <= 1'b0;
      flags    <= '0;
    end else begin
      if (stb.ctrlWe) begin
        lowBits  <= wrCtrl[LOW_W-1:0];
        busErr   <= wrCtrl[BERR_BIT];
        chEn     <= wrCtrl[MEN_BIT-1:EN_LO];
        masterEn <= wrCtrl[MEN_BIT];
      end
      if (stb.busErrSet) busErr <= 1'b1;
      flags <= (flags & ~stb.flagClr) | stb.flagSet;
    end
  end

  assign masterFlag = busErr | (masterEn & (|flags));
  assign irqOut     = masterFlag;
  assign regWord    = {masterFlag, flags, masterEn, chEn, busErr, lowBits};

  a_r6_buserr_sticks: assert property (@(posedge clk) disable iff (!rstN)
    stb.busErrSet |=> busErr);
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.flagSet != '0) |=> ((flags & $past(stb.flagSet)) == $past(stb.flagSet)));
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CH_COUNT-1:0] doneStb,
  input  logic [CH_COUNT-1:0] busErrStb,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  strobe_t             stb;
  logic [CH_COUNT-1:0] chEn;
  logic                masterEn;

  dma_irq_strobe_gen u_ctrl (
    .wrEn      (wrEn),
    .wrClr     (wrData[MFLAG_BIT-1:FLAG_LO]),
    .doneStb   (doneStb),
    .busErrStb (busErrStb),
    .chEn      (chEn),
    .masterEn  (masterEn),
    .stb       (stb)
  );

  dma_irq_regfile u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrCtrl   (wrData[MEN_BIT:0]),
    .chEn     (chEn),
    .masterEn (masterEn),
    .regWord  (rdData),
    .irqOut   (irqOut)
  );

  a_r2_write_stores: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busErrStb == '0) |=> (rdData[MEN_BIT:0] == $past(wrData[MEN_BIT:0])));
  a_r6_buserr_irq: assert property (@(posedge clk) disable iff (!rstN)
    (|busErrStb) |=> (rdData[BERR_BIT] && irqOut));
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && doneStb == '0 && busErrStb == '0)
      |=> ((rdData[MFLAG_BIT-1:FLAG_LO] & $past(wrData[MFLAG_BIT-1:FLAG_LO])) == '0));
  a_r5_no_gated_set: assert property (@(posedge clk) disable iff (!rstN)
    (busErrStb == '0 && (!rdData[MEN_BIT] || (doneStb & rdData[MEN_BIT-1:EN_LO]) == '0))
      |=> ((rdData[MFLAG_BIT-1:FLAG_LO] & ~$past(rdData[MFLAG_BIT-1:FLAG_LO])) == '0));
  a_r10_low_holds: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData[LOW_W-1:0]));
endmodule

// File: tb/tb_dma_irq_ctrl.sv
`timescale 1ns/1ps
module tb_dma_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [6:0]  doneStb = '0;
  logic [6:0]  busErrStb = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int testsRun = 0;
  int testsFailed = 0;

  typedef struct {
    logic [31:0] word;
    logic        irq;
    string       req;
  } exp_t;
  exp_t expQ[$];

  // bench-side model state
  logic [14:0] mLow = '0;
  logic        mBerr = 1'b0;
  logic [6:0]  mEn = '0;
  logic        mMen = 1'b0;
  logic [6:0]  mFlags = '0;

  always #10 clk = ~clk;

  dma_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .doneStb(doneStb), .busErrStb(busErrStb), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic modelIrq();
    return mBerr | (mMen & (|mFlags));
  endfunction

  task automatic step(input logic we, input logic [31:0] d, input logic [6:0] done,
                      input logic [6:0] berr, input string req);
    exp_t e;
    logic [6:0] nf;
    logic       nb;
    @(negedge clk);
    wrEn = we; wrData = d; doneStb = done; busErrStb = berr;
    nf = mFlags;
    if (we) nf = nf & ~d[30:24];
    for (int c = 0; c < 7; c++) begin
      if (done[c] && mEn[c] && mMen) nf[c] = 1'b1;
      if (berr[c]) nf[c] = 1'b1;
    end
    nb = we ? d[15] : mBerr;
    if (|berr) nb = 1'b1;
    if (we) begin
      mLow = d[14:0]; mEn = d[22:16]; mMen = d[23];
    end
    mBerr = nb; mFlags = nf;
    @(posedge clk);
    #1;
    wrEn = 1'b0; doneStb = '0; busErrStb = '0;
    e.irq  = modelIrq();
    e.word = {e.irq, mFlags, mMen, mEn, mBerr, mLow};
    e.req  = req;
    expQ.push_back(e);
  endtask

  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      testsRun++;
      if (rdData !== e.word || irqOut !== e.irq) begin
        testsFailed++;
        $display("FAIL %s: rdData=%h irq=%b expected rdData=%h irq=%b",
                 e.req, rdData, irqOut, e.word, e.irq);
      end
    end
  end

  initial begin
    #(200000 * 20);
    testsFailed++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testsRun++;
    if (rdData !== 32'h0 || irqOut !== 1'b0) begin
      testsFailed++;
      $display("FAIL R1: rdData=%h irq=%b expected rdData=00000000 irq=0", rdData, irqOut);
    end
    @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 32'h0, 7'h00, 7'h00, "R1 idle after reset");
    step(1'b1, 32'h0000_1234, 7'h00, 7'h00, "R2/R10 low storage write");
    step(1'b1, 32'h00FF_5A5A, 7'h00, 7'h00, "R2 enables and master");
    step(1'b0, 32'h0, 7'h04, 7'h00, "R4/R9 completion sets flag");
    step(1'b1, 32'h807F_5A5A, 7'h00, 7'h00, "R3/R7/R9 bit31 ignored, master off");
    step(1'b0, 32'h0, 7'h08, 7'h00, "R5 master enable off");
    step(1'b1, 32'h00F7_5A5A, 7'h00, 7'h00, "R2/R9 master back on");
    step(1'b0, 32'h0, 7'h08, 7'h00, "R5 channel enable off");
    step(1'b1, 32'h04F7_5A5A, 7'h00, 7'h00, "R7 one clears flag");
    step(1'b1, 32'h02F7_5A5A, 7'h02, 7'h00, "R8 set beats clear");
    step(1'b0, 32'h0, 7'h7F, 7'h00, "R4/R5 many completions");
    step(1'b1, 32'h7F00_0000, 7'h00, 7'h00, "R7 clear all, disable all");
    step(1'b0, 32'h0, 7'h00, 7'h20, "R6 bus error with enables off");
    step(1'b1, 32'h2000_0000, 7'h00, 7'h00, "R6/R9 clear bus error and flag");
    step(1'b1, 32'h0000_0000, 7'h00, 7'h01, "R6 bus error beats write of bit15");
    step(1'b1, 32'h0100_0000, 7'h00, 7'h00, "R9 clear after bus error");
    step(1'b1, 32'h0000_7FFF, 7'h00, 7'h00, "R10 low bits no interrupt");
    step(1'b0, 32'h0, 7'h00, 7'h00, "R7/R10 hold without write");
    @(negedge clk);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule